// File: doc/BRIEF.md
# Button-Steered Slow Four-Bit LED Counter

This block drives a four-bit count onto four LED outputs and moves it at a rate slow enough for the eye to follow. A prescaler counts system clock cycles and emits a one-cycle enable tick at the end of every period. With the default period of 100,000,000 cycles at 100 MHz, that is one tick per second. No derived clock exists: every flop runs on `clk_i`, and the counter register is qualified by the tick.

Two push-button inputs choose what happens on each tick. Up increments, down decrements, and no button or both buttons hold the value. Both buttons first pass through a two-flop synchroniser. The count wraps modulo 16 in both directions. The tick period is a parameter, so a bench can shorten it. The active-low asynchronous reset clears the count, the prescaler and the synchronisers.

Top module: `led_step_counter`

## Requirements
- R1: While `rst_ni` is low, and at the first sample after it rises, `led_o` reads 0. The prescaler also restarts from zero, so the first tick falls on the TICK_DIV-th rising edge after reset is released.
- R2: `led_o` changes only on the rising edge that completes each TICK_DIV-cycle period (edges TICK_DIV, 2·TICK_DIV, ... counted from reset release). Between those edges it is stable.
- R3: With only the up button (`btn_up_i` = 1) held, each tick adds one to `led_o`.
- R4: With only the down button (`btn_dn_i` = 1) held, each tick subtracts one from `led_o`.
- R5: With neither button pressed, a tick leaves `led_o` unchanged.
- R6: With both buttons pressed, a tick leaves `led_o` unchanged.
- R7: Counting up from 15 gives 0.
- R8: Counting down from 0 gives 15.
- R9: Each button reaches the counter through two flops. A press first applied one rising edge before a tick edge is not seen by that tick. A press of one cycle placed away from any tick does not change `led_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| btn_up_i | input | 1 | Up push button, asynchronous, active high |
| btn_dn_i | input | 1 | Down push button, asynchronous, active high |
| led_o | output | 4 | Current count, drives the LEDs |

## Verification
A new count appears on `led_o` right after the edge that completes each period. That edge uses the button levels that were present at least two edges earlier, because of the synchroniser. The bench therefore changes buttons on the falling edge that follows a tick edge. It checks the count mid-period for stability, then again on the falling edge after the next tick edge. The latency and short-pulse cases move the button change to one cycle before a tick edge and to mid-period, where the expected result is no step.

// File: rtl/led_step_counter_pkg.sv
package led_step_counter_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end

      // R9: second stage follows the first one edge later
      p_sync_shift_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ff_q[1] == $past(ff_q[0]));
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int unsigned TICK_DIV = 100_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end

  assign tick_o = (pre_q == LAST);

  p_pre_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= LAST);

  generate
    if (TICK_DIV > 1) begin : g_gap
      p_tick_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/step_select.sv
module step_select
  import led_step_counter_pkg::*;
(
  input  logic  up_i,
  input  logic  dn_i,
  output step_e step_o
);
  always_comb begin
    unique case ({up_i, dn_i})
      2'b10:   step_o = STEP_INC;
      2'b01:   step_o = STEP_DEC;
      default: step_o = STEP_HOLD;
    endcase
  end
endmodule

// File: rtl/count_core.sv
module count_core
  import led_step_counter_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  step_e            step_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) begin
      unique case (step_i)
        STEP_INC: cnt_d = cnt_q + 1'b1;
        STEP_DEC: cnt_d = cnt_q - 1'b1;
        default:  cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_still_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  p_inc_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && step_i == STEP_INC) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  p_dec_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && step_i == STEP_DEC) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && step_i == STEP_HOLD) |=> $stable(cnt_q));
endmodule

// File: rtl/led_step_counter.sv
module led_step_counter
  import led_step_counter_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 100_000_000,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             btn_up_i,
  input  logic             btn_dn_i,
  output logic [CNT_W-1:0] led_o
);
  localparam int unsigned NUM_BTN = 2;

  logic [NUM_BTN-1:0] btn_raw, btn_s;
  logic               tick;
  step_e              step;
  logic [CNT_W-1:0]   cnt;

  assign btn_raw = {btn_dn_i, btn_up_i};

  generate
    for (genvar b = 0; b < NUM_BTN; b++) begin : g_sync
      btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (btn_raw[b]),
        .q_o   (btn_s[b])
      );
    end
  endgenerate

  tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  step_select u_sel (
    .up_i  (btn_s[0]),
    .dn_i  (btn_s[1]),
    .step_o(step)
  );

  count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .step_i(step),
    .cnt_o (cnt)
  );

  assign led_o = cnt;

  // R6: both synchronised buttons pressed means no step
  p_both_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && btn_s[0] && btn_s[1]) |=> $stable(led_o));
endmodule

// File: tb/tb_led_step_counter.sv
module tb_led_step_counter;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up = 1'b0;
  logic       dn = 1'b0;
  logic [3:0] led;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] exp_cnt = 4'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_step_counter #(.TICK_DIV(DIV)) dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .btn_up_i(up),
    .btn_dn_i(dn),
    .led_o   (led)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: led_o=%0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Starts and ends on the falling edge right after a tick edge.
  task automatic run_period(input logic u, input logic d, input string tag);
    up = u; dn = d;
    repeat (DIV/2) @(negedge clk);
    check("R2 mid-period", led, exp_cnt);
    repeat (DIV - DIV/2) @(negedge clk);
    if (u && !d)      exp_cnt = exp_cnt + 4'd1;
    else if (d && !u) exp_cnt = exp_cnt - 4'd1;
    check(tag, led, exp_cnt);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; up = 1'b0; dn = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", led, 4'd0);
    rst_n = 1'b1;
    exp_cnt = 4'd0;
    @(negedge clk);
    check("R1 after release", led, 4'd0);
    repeat (DIV - 2) @(negedge clk);
    check("R1 no early tick", led, 4'd0);
    @(negedge clk);
    check("R1 first tick hold", led, 4'd0);
  endtask

  task automatic t_up();
    for (int i = 0; i < 3; i++) run_period(1'b1, 1'b0, "R3 increment");
  endtask

  task automatic t_wrap_up();
    while (exp_cnt != 4'd15) run_period(1'b1, 1'b0, "R3 increment");
    run_period(1'b1, 1'b0, "R7 wrap 15->0");
  endtask

  task automatic t_wrap_down();
    run_period(1'b0, 1'b1, "R8 wrap 0->15");
  endtask

  task automatic t_down();
    for (int i = 0; i < 2; i++) run_period(1'b0, 1'b1, "R4 decrement");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 2; i++) run_period(1'b0, 1'b0, "R5 idle hold");
  endtask

  task automatic t_both();
    for (int i = 0; i < 2; i++) run_period(1'b1, 1'b1, "R6 both hold");
  endtask

  task automatic t_late_press();
    up = 1'b0; dn = 1'b0;
    repeat (DIV - 2) @(negedge clk);
    up = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 late press ignored", led, exp_cnt);
    run_period(1'b1, 1'b0, "R9 press seen next tick");
  endtask

  task automatic t_short_pulse();
    up = 1'b0; dn = 1'b0;
    repeat (2) @(negedge clk);
    dn = 1'b1;
    @(negedge clk);
    dn = 1'b0;
    repeat (DIV - 3) @(negedge clk);
    check("R9 short pulse ignored", led, exp_cnt);
  endtask

  task automatic t_reset_mid();
    run_period(1'b1, 1'b0, "R3 increment");
    t_reset();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_up();
    t_wrap_up();
    t_wrap_down();
    t_down();
    t_idle();
    t_both();
    t_late_press();
    t_short_pulse();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule